// File: doc/BRIEF.md
# Flash Rewrite Controller with Erase Suspend

This block lets a processor rewrite an on-chip flash array through commands. A command word selects array read, status read, status clear, word program or block erase. Program and erase run as timed automatic operations against a built-in behavioural flash model. Program takes a fixed number of cycles. Erase takes a fixed number of cycles and can be suspended between cycles so that other blocks can be read in the meantime.

Two rewrite modes are selected by `mode_sel`. In mode 0 the processor keeps running and polls the ready bit, and the read port shows the status word once an operation ends. In mode 1 the processor is held (`cpu_hold`) for as long as an operation runs, and the read port returns to array data once it ends. The status-read command is ignored in mode 1. Mode 1 also refuses rewrites of the block that holds the running rewrite code, given by `exec_blk`.

Erase suspend has a different trigger in each mode. In mode 0 software sets both `susp_en` and `susp_req`. In mode 1 an enabled pending interrupt arrives while `susp_en` is 1. Only blocks below `NUM_USER_BLK` may be rewritten, and the lowest `NUM_LOW_BLK` blocks need `low_blk_wen` as well.

Top module: `flash_rewrite_ctrl`

## Requirements
- R1: A program command (`cmd_op`=3) to a permitted block, given while `ready`=1, drops `ready` at the accepting edge and raises it again exactly PROG_CYC (8) edges later. The addressed word then holds its old value AND `cmd_data`.
- R2: A block-erase command (`cmd_op`=4) to a permitted block drops `ready` for exactly ERASE_CYC (64) edges when not suspended. All 16 words of the block (address bits [7:4]) then read 0xFF, and no other block changes.
- R3: A program or erase aimed at a block index of NUM_USER_BLK (12) or above is refused. `ready` stays 1, the array is unchanged, and `prog_err` (for program) or `erase_err` (for erase) is set.
- R4: Program or erase of block 0 or 1 is refused in the same way as R3 while `low_blk_wen`=0, and is carried out while `low_blk_wen`=1.
- R5: In mode 1 (`mode_sel`=1), program or erase of the block equal to `exec_blk` is refused in the same way as R3.
- R6: When an operation completes, the read port shows the status word if `mode_sel`=0 and array data if `mode_sel`=1.
- R7: The status-read command (`cmd_op`=1) switches the read port to the status word in mode 0 and is ignored in mode 1. The status word has `ready` at bit 7, `erase_err` at bit 1, `prog_err` at bit 0 and zeros elsewhere. The array-read command (`cmd_op`=0) selects array data.
- R8: In mode 0, erase suspend starts one edge after `susp_en` and `susp_req` are both 1, and never with `susp_en` alone. It ends at the first edge on which either bit is 0. Each suspended edge adds one edge to the erase time.
- R9: In mode 1, erase suspend starts one edge after `irq_pend` and `susp_en` are both 1, and ends at the first edge with `irq_pend`=0. Each suspended edge adds one edge to the erase time.
- R10: While suspended, `suspended`=1 and `ready`=0. Array reads of other blocks return their contents, and reads of the block being erased return all ones.
- R11: `cpu_hold` is 1 in mode 1 while an operation runs and is not suspended. It is 0 in mode 0 and while suspended.
- R12: `prog_err` and `erase_err` stay set until a clear-status command (`cmd_op`=2) clears them. Both flags and `ready` are visible on the ports in both modes.
- R13: After reset `ready`=1, both error flags and `suspended` are 0, the read port shows array data, and every word reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 1 | Rewrite mode: 0 or 1 |
| low_blk_wen | input | 1 | Rewrite enable for the lowest blocks |
| susp_en | input | 1 | Erase-suspend enable |
| susp_req | input | 1 | Software suspend request (mode 0) |
| irq_pend | input | 1 | Enabled interrupt pending (mode 1 suspend trigger) |
| exec_blk | input | BLK_IDX_W (4) | Block holding the running rewrite code |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | ADDR_W (8) | Word address of the command |
| cmd_data | input | DATA_W (8) | Program data |
| rd_addr | input | ADDR_W (8) | Read address |
| rd_data | output | DATA_W (8) | Array word or status word |
| ready | output | 1 | No operation in progress |
| erase_err | output | 1 | Sticky erase refusal flag |
| prog_err | output | 1 | Sticky program refusal flag |
| suspended | output | 1 | Erase currently suspended |
| cpu_hold | output | 1 | Processor hold request in mode 1 |

## Verification
`ready` falls half a cycle after the accepting edge. From the negative edge after acceptance, the bench counts negative edges until `ready` returns and expects 8 for a program and 64 for an erase, plus one per suspended edge. Refusals and status-flag changes show up at the first negative edge after the command edge. `suspended` rises one edge after its trigger is applied, so the bench samples it from that point on. `rd_data` is combinational on `rd_addr` and is read 1 ns after the address is set, well away from any edge.

// File: rtl/flash_rw_pkg.sv
`timescale 1ns/1ps
package flash_rw_pkg;
   typedef enum logic [2:0] {
      OP_RD_ARRAY   = 3'd0,
      OP_RD_STATUS  = 3'd1,
      OP_CLR_STATUS = 3'd2,
      OP_PROGRAM    = 3'd3,
      OP_ERASE      = 3'd4
   } fr_op_e;

   typedef enum logic {
      RM_ARRAY  = 1'b0,
      RM_STATUS = 1'b1
   } fr_rdmode_e;
endpackage

// File: rtl/fr_cmd_guard.sv
`timescale 1ns/1ps
module fr_cmd_guard #(
   parameter int NUM_BLK      = 16,
   parameter int NUM_USER_BLK = 12,
   parameter int NUM_LOW_BLK  = 2,
   parameter int BLK_IDX_W    = 4
)(
   input  logic [BLK_IDX_W-1:0] tgt_blk,
   input  logic [BLK_IDX_W-1:0] exec_blk,
   input  logic                 mode1,
   input  logic                 low_wen,
   output logic                 allow
);
   logic in_user;
   logic low_ok;

   if (NUM_USER_BLK > NUM_BLK || NUM_USER_BLK < 1) begin : g_bad_user
      $error("NUM_USER_BLK must lie in 1..NUM_BLK");
   end
   if (NUM_LOW_BLK > NUM_USER_BLK) begin : g_bad_low
      $error("NUM_LOW_BLK must not exceed NUM_USER_BLK");
   end

   // Range check is only built when part of the array lies outside user space
   if (NUM_USER_BLK < NUM_BLK) begin : g_range
      assign in_user = 32'(tgt_blk) < 32'(NUM_USER_BLK);
   end else begin : g_full
      assign in_user = 1'b1;
   end

   if (NUM_LOW_BLK > 0) begin : g_low
      assign low_ok = low_wen || (32'(tgt_blk) >= 32'(NUM_LOW_BLK));
   end else begin : g_nolow
      assign low_ok = 1'b1;
   end

   always_comb begin
      allow = in_user && low_ok;
      if (mode1 && tgt_blk == exec_blk) allow = 1'b0;
   end
endmodule

// File: rtl/fr_op_timer.sv
`timescale 1ns/1ps
module fr_op_timer #(
   parameter int PROG_CYC  = 8,
   parameter int ERASE_CYC = 64
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic start_erase,
   input  logic mode1,
   input  logic susp_en,
   input  logic susp_req,
   input  logic irq_pend,
   output logic busy,
   output logic erasing,
   output logic suspended,
   output logic done
);
   localparam int CNT_W = $clog2(ERASE_CYC + 1);

   if (PROG_CYC < 2 || ERASE_CYC < PROG_CYC) begin : g_bad_cyc
      $error("need 2 <= PROG_CYC <= ERASE_CYC");
   end

   logic [CNT_W-1:0] cnt;
   logic             enter_susp;
   logic             keep_susp;

   always_comb begin
      if (mode1) begin
         enter_susp = susp_en && irq_pend;
         keep_susp  = irq_pend;
      end else begin
         enter_susp = susp_en && susp_req;
         keep_susp  = susp_en && susp_req;
      end
   end

   assign done = busy && !suspended && cnt == CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         busy      <= 1'b0;
         erasing   <= 1'b0;
         suspended <= 1'b0;
      end else if (start) begin
         busy    <= 1'b1;
         erasing <= start_erase;
         cnt     <= start_erase ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC);
      end else if (busy && !suspended) begin
         if (cnt == CNT_W'(1)) begin
            busy    <= 1'b0;
            erasing <= 1'b0;
         end else begin
            cnt <= cnt - CNT_W'(1);
            // the cycle in progress completes; suspension starts after it
            if (erasing && enter_susp) suspended <= 1'b1;
         end
      end else if (suspended && !keep_susp) begin
         suspended <= 1'b0;
      end
   end

   a_r8_cnt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      suspended |=> $stable(cnt));
   a_r10_susp_only_in_erase: assert property (@(posedge clk) disable iff (!rst_n)
      suspended |-> (busy && erasing));
   a_r8_entry_mode0: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(suspended) && !$past(mode1)) |-> $past(susp_en && susp_req));
   a_r9_entry_mode1: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(suspended) && $past(mode1)) |-> $past(susp_en && irq_pend));
endmodule

// File: rtl/fr_array_model.sv
`timescale 1ns/1ps
module fr_array_model #(
   parameter int DATA_W         = 8,
   parameter int ADDR_W         = 8,
   parameter int BLK_WORDS_LOG2 = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_we,
   input  logic              erase_we,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_word
);
   localparam int DEPTH     = 1 << ADDR_W;
   localparam int BLK_WORDS = 1 << BLK_WORDS_LOG2;
   localparam int BIDX_W    = ADDR_W - BLK_WORDS_LOG2;

   if (BLK_WORDS_LOG2 < 1 || BIDX_W < 1) begin : g_bad_geom
      $error("array needs at least two blocks of at least two words");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   assign rd_word = mem[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (erase_we) begin
         for (int w = 0; w < BLK_WORDS; w++)
            mem[{wr_addr[ADDR_W-1:BLK_WORDS_LOG2], BLK_WORDS_LOG2'(w)}] <= '1;
      end else if (prog_we) begin
         // programming can only clear bits
         mem[wr_addr] <= mem[wr_addr] & wr_data;
      end
   end
endmodule

// File: rtl/flash_rewrite_ctrl.sv
`timescale 1ns/1ps
module flash_rewrite_ctrl
   import flash_rw_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int BLK_WORDS_LOG2 = 4,
   parameter int NUM_BLK        = 16,
   parameter int NUM_USER_BLK   = 12,
   parameter int NUM_LOW_BLK    = 2,
   parameter int PROG_CYC       = 8,
   parameter int ERASE_CYC      = 64,
   localparam int BLK_IDX_W     = $clog2(NUM_BLK),
   localparam int ADDR_W        = BLK_IDX_W + BLK_WORDS_LOG2
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode_sel,
   input  logic                 low_blk_wen,
   input  logic                 susp_en,
   input  logic                 susp_req,
   input  logic                 irq_pend,
   input  logic [BLK_IDX_W-1:0] exec_blk,
   input  logic                 cmd_valid,
   input  logic [2:0]           cmd_op,
   input  logic [ADDR_W-1:0]    cmd_addr,
   input  logic [DATA_W-1:0]    cmd_data,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [DATA_W-1:0]    rd_data,
   output logic                 ready,
   output logic                 erase_err,
   output logic                 prog_err,
   output logic                 suspended,
   output logic                 cpu_hold
);
   if (DATA_W < 3) begin : g_bad_width
      $error("DATA_W must hold the status word");
   end
   if ((1 << BLK_IDX_W) != NUM_BLK) begin : g_bad_blk
      $error("NUM_BLK must be a power of two");
   end

   fr_op_e            op;
   fr_rdmode_e        rmode;
   logic              is_prog, is_erase, allow, accept_rw, refuse;
   logic              busy, erasing, done;
   logic [ADDR_W-1:0] op_addr;
   logic [DATA_W-1:0] op_data, arr_word, stat_word;
   logic              rd_blocked;

   assign op       = fr_op_e'(cmd_op);
   assign is_prog  = cmd_valid && op == OP_PROGRAM;
   assign is_erase = cmd_valid && op == OP_ERASE;

   fr_cmd_guard #(
      .NUM_BLK(NUM_BLK), .NUM_USER_BLK(NUM_USER_BLK),
      .NUM_LOW_BLK(NUM_LOW_BLK), .BLK_IDX_W(BLK_IDX_W)
   ) u_guard (
      .tgt_blk (cmd_addr[ADDR_W-1:BLK_WORDS_LOG2]),
      .exec_blk(exec_blk),
      .mode1   (mode_sel),
      .low_wen (low_blk_wen),
      .allow   (allow)
   );

   assign accept_rw = (is_prog || is_erase) && !busy && allow;
   assign refuse    = (is_prog || is_erase) && !busy && !allow;

   fr_op_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .start(accept_rw), .start_erase(is_erase), .mode1(mode_sel),
      .susp_en(susp_en), .susp_req(susp_req), .irq_pend(irq_pend),
      .busy(busy), .erasing(erasing), .suspended(suspended), .done(done)
   );

   fr_array_model #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BLK_WORDS_LOG2(BLK_WORDS_LOG2)
   ) u_array (
      .clk(clk), .rst_n(rst_n),
      .prog_we (done && !erasing),
      .erase_we(done && erasing),
      .wr_addr (op_addr),
      .wr_data (op_data),
      .rd_addr (rd_addr),
      .rd_word (arr_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rmode     <= RM_ARRAY;
         prog_err  <= 1'b0;
         erase_err <= 1'b0;
         op_addr   <= '0;
         op_data   <= '0;
      end else begin
         if (cmd_valid) begin
            case (op)
               OP_RD_ARRAY:   rmode <= RM_ARRAY;
               OP_RD_STATUS:  if (!mode_sel) rmode <= RM_STATUS;
               OP_CLR_STATUS: begin
                  prog_err  <= 1'b0;
                  erase_err <= 1'b0;
               end
               default: ;
            endcase
         end
         if (refuse && is_prog)  prog_err  <= 1'b1;
         if (refuse && is_erase) erase_err <= 1'b1;
         if (accept_rw) begin
            op_addr <= cmd_addr;
            op_data <= cmd_data;
         end
         if (done) rmode <= mode_sel ? RM_ARRAY : RM_STATUS;
      end
   end

   always_comb begin
      stat_word           = '0;
      stat_word[DATA_W-1] = !busy;
      stat_word[1]        = erase_err;
      stat_word[0]        = prog_err;
   end

   assign rd_blocked = busy && (!suspended ||
      rd_addr[ADDR_W-1:BLK_WORDS_LOG2] == op_addr[ADDR_W-1:BLK_WORDS_LOG2]);
   assign rd_data  = (rmode == RM_STATUS) ? stat_word : (rd_blocked ? '1 : arr_word);
   assign ready    = !busy;
   assign cpu_hold = mode_sel && busy && !suspended;

   a_r3_refused_stays_ready: assert property (@(posedge clk) disable iff (!rst_n)
      refuse |=> ready);
   a_r12_prog_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_err && !(cmd_valid && op == OP_CLR_STATUS)) |=> prog_err);
   a_r12_erase_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_err && !(cmd_valid && op == OP_CLR_STATUS)) |=> erase_err);
   a_r6_mode1_array_after: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ready) && $past(mode_sel)) |-> rmode == RM_ARRAY);
   a_r11_no_hold_suspended: assert property (@(posedge clk) disable iff (!rst_n)
      suspended |-> !cpu_hold);
endmodule

// File: tb/tb_flash_rewrite_ctrl.sv
`timescale 1ns/1ps
module tb_flash_rewrite_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_sel = 1'b0, low_blk_wen = 1'b0, susp_en = 1'b0, susp_req = 1'b0, irq_pend = 1'b0;
   logic [3:0] exec_blk = 4'd15;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_op = 3'd0;
   logic [7:0] cmd_addr = 8'd0, cmd_data = 8'd0, rd_addr = 8'd0;
   logic [7:0] rd_data;
   logic       ready, erase_err, prog_err, suspended, cpu_hold;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] mdl [256];

   always #2.5 clk = ~clk;

   flash_rewrite_ctrl dut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .low_blk_wen(low_blk_wen),
      .susp_en(susp_en), .susp_req(susp_req), .irq_pend(irq_pend), .exec_blk(exec_blk),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready), .erase_err(erase_err),
      .prog_err(prog_err), .suspended(suspended), .cpu_hold(cpu_hold)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit permitted(input logic [3:0] b, input logic m1, input logic lw,
                                    input logic [3:0] ex);
      return (b < 4'd12) && (b >= 4'd2 || lw) && !(m1 && b == ex);
   endfunction

   task automatic issue(input logic [2:0] op, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic wait_ready(output int n);
      n = 0;
      while (!ready && n < 300) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic apply_model(input bit er, input logic [7:0] a, input logic [7:0] d);
      if (er) begin
         for (int i = 0; i < 16; i++) mdl[{a[7:4], 4'(i)}] = 8'hFF;
      end else begin
         mdl[a] = mdl[a] & d;
      end
   endtask

   // one program/erase with full expectation checks
   task automatic run_op(input bit er, input logic [7:0] a, input logic [7:0] d);
      bit ok;
      int n;
      logic [7:0] v;
      logic [7:0] probe;
      ok = permitted(a[7:4], mode_sel, low_blk_wen, exec_blk);
      issue(er ? 3'd4 : 3'd3, a, d);
      if (ok) begin
         chk(er ? "R2 busy after accept" : "R1 busy after accept", ready, 0);
         wait_ready(n);
         chk(er ? "R2 erase duration" : "R1 program duration", n, er ? 64 : 8);
         apply_model(er, a, d);
         if (mode_sel) begin
            rd(a, v);
            chk("R6 mode1 array after op", v, mdl[a]);
         end else begin
            rd(a, v);
            chk("R6 mode0 status after op", v, 8'h80);
            issue(3'd0, 8'h00, 8'h00);
         end
         probe = er ? {a[7:4], 4'($urandom % 16)} : a;
         rd(probe, v);
         chk(er ? "R2 erased word" : "R1 programmed word", v, mdl[probe]);
      end else begin
         chk("R3 R4 R5 refused keeps ready", ready, 1);
         chk("R3 R4 R5 error flag", er ? erase_err : prog_err, 1);
         chk("R3 R4 R5 other flag clear", er ? prog_err : erase_err, 0);
         issue(3'd2, 8'h00, 8'h00);
         chk("R12 flags cleared", {erase_err, prog_err}, 0);
         issue(3'd0, 8'h00, 8'h00);
         rd(a, v);
         chk("R3 array unchanged", v, mdl[a]);
      end
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      int n;
      void'($urandom(32'd20061));
      for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R13 reset state
      chk("R13 ready", ready, 1);
      chk("R13 flags", {erase_err, prog_err, suspended}, 0);
      chk("R11 no hold at reset", cpu_hold, 0);
      rd(8'h35, v);
      chk("R13 erased array", v, 8'hFF);

      // R7 status read in mode 0
      issue(3'd1, 8'h00, 8'h00);
      rd(8'h35, v);
      chk("R7 mode0 status word", v, 8'h80);
      issue(3'd0, 8'h00, 8'h00);

      // R1 program twice: bits only clear
      run_op(1'b0, 8'h35, 8'hA5);
      run_op(1'b0, 8'h35, 8'h3C);
      run_op(1'b0, 8'h4A, 8'h5A);

      // R3 outside user region, status word shows the error bit
      issue(3'd3, 8'hC0, 8'h00);
      chk("R3 prog_err set", prog_err, 1);
      issue(3'd1, 8'h00, 8'h00);
      rd(8'h00, v);
      chk("R7 R12 status with prog error", v, 8'h81);
      issue(3'd2, 8'h00, 8'h00);
      issue(3'd0, 8'h00, 8'h00);
      run_op(1'b1, 8'hF3, 8'h00);

      // R4 low block gate
      low_blk_wen = 1'b0;
      run_op(1'b0, 8'h12, 8'h0F);
      low_blk_wen = 1'b1;
      run_op(1'b0, 8'h12, 8'h0F);
      low_blk_wen = 1'b0;

      // R2 erase block 3, block 4 kept
      run_op(1'b1, 8'h30, 8'h00);
      rd(8'h4A, v);
      chk("R2 neighbour block kept", v, mdl[8'h4A]);

      // R8 mode 0 suspend
      issue(3'd3, 8'h73, 8'h11);
      wait_ready(n);
      mdl[8'h73] = mdl[8'h73] & 8'h11;
      issue(3'd0, 8'h00, 8'h00);
      issue(3'd4, 8'h70, 8'h00);
      n = 0;
      susp_en = 1'b1;
      repeat (5) begin
         @(negedge clk); n++;
         chk("R8 enable alone no suspend", suspended, 0);
      end
      susp_req = 1'b1;
      repeat (20) begin
         @(negedge clk); n++;
         chk("R8 suspended", suspended, 1);
         chk("R10 ready low in suspend", ready, 0);
         chk("R11 mode0 no hold", cpu_hold, 0);
         rd(8'h4A, v);
         chk("R10 other block readable", v, mdl[8'h4A]);
         rd(8'h73, v);
         chk("R10 erasing block reads ones", v, 8'hFF);
      end
      susp_req = 1'b0;
      @(negedge clk); n++;
      chk("R8 resumed", suspended, 0);
      susp_en = 1'b0;
      while (!ready && n < 300) begin @(negedge clk); n++; end
      chk("R8 erase time with suspend", n, 84);
      apply_model(1'b1, 8'h70, 8'h00);
      issue(3'd0, 8'h00, 8'h00);
      rd(8'h73, v);
      chk("R8 erase finished", v, 8'hFF);

      // mode 1
      mode_sel = 1'b1;
      exec_blk = 4'd15;
      issue(3'd3, 8'h58, 8'hC3);
      chk("R11 mode1 hold while busy", cpu_hold, 1);
      wait_ready(n);
      chk("R1 mode1 program duration", n, 8);
      mdl[8'h58] = mdl[8'h58] & 8'hC3;
      chk("R11 hold released", cpu_hold, 0);
      rd(8'h58, v);
      chk("R6 mode1 array after op", v, mdl[8'h58]);
      issue(3'd1, 8'h00, 8'h00);
      rd(8'h58, v);
      chk("R7 mode1 status read ignored", v, mdl[8'h58]);
      chk("R12 ready visible mode1", ready, 1);
      exec_blk = 4'd5;
      run_op(1'b0, 8'h59, 8'h00);
      run_op(1'b1, 8'h50, 8'h00);

      // R9 interrupt suspend in mode 1
      exec_blk = 4'd15;
      issue(3'd4, 8'h60, 8'h00);
      n = 0;
      irq_pend = 1'b1;
      repeat (4) begin
         @(negedge clk); n++;
         chk("R9 irq without enable", suspended, 0);
         chk("R11 hold during erase", cpu_hold, 1);
      end
      susp_en = 1'b1;
      repeat (10) begin
         @(negedge clk); n++;
         chk("R9 suspended on irq", suspended, 1);
         chk("R11 no hold in suspend", cpu_hold, 0);
         rd(8'h58, v);
         chk("R10 mode1 other block readable", v, mdl[8'h58]);
      end
      irq_pend = 1'b0;
      @(negedge clk); n++;
      chk("R9 resumed", suspended, 0);
      susp_en = 1'b0;
      while (!ready && n < 300) begin @(negedge clk); n++; end
      chk("R9 erase time with suspend", n, 74);
      apply_model(1'b1, 8'h60, 8'h00);

      // constrained random mix
      for (int it = 0; it < 40; it++) begin
         logic [7:0] a, d;
         bit er;
         @(negedge clk);
         mode_sel    = 1'($urandom % 2);
         low_blk_wen = 1'($urandom % 2);
         exec_blk    = 4'($urandom % 16);
         a  = 8'($urandom % 256);
         d  = 8'($urandom % 256);
         er = ($urandom % 4) == 0;
         issue(3'd0, 8'h00, 8'h00);
         run_op(er, a, d);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule